// File: doc/BRIEF.md
# Serial Control Register Bank

This block is a write-only control port driven over three wires: a serial clock, a serial data line and a latch line. A host shifts a 16-bit control word into it. When the latch line rises, the block splits the word into a 7-bit register address and a 9-bit data value. It then writes the addressed register in the bank that sets up a multi-channel audio output path. The serial lines are treated as asynchronous. They pass through synchronisers into the system clock domain, and the block acts on the rising edges it sees there.

Every channel has an analogue attenuation level and a digital attenuation level. Both are double-buffered. A write lands in a staging copy first. A write with the commit flag set moves every staged level to the live outputs in one clock cycle, so a volume change on several channels takes effect all at once. The zero-cross enable and the per-channel mute mask are not buffered and change as soon as they are written. A dedicated address restores every register to its default, which is the same state that the hardware reset produces. Read-back, addressed multi-device buses and analogue functions are out of scope.

There is no streaming data path, so the block has no valid/ready handshake and therefore no back-pressure. All pins are plain control pins.

Top module: `serctl_bank`

## Requirements
- R1: Bits are shifted in MSB first, one per rising edge of `ser_clk`. After exactly 16 such edges, a rising edge of `ser_lat` accepts the word: bits 15:9 are the address and bits 8:0 are the data. The result appears on the outputs within 4 rising `clk` edges of the first `clk` edge that samples `ser_lat` high.
- R2: If the number of `ser_clk` rising edges since the previous latch edge is anything other than 16, the latch edge is ignored.
- R3: A write to an attenuation register with data bit 8 = 0 changes only that channel's staged level. No live attenuation output changes.
- R4: A write to an attenuation register with data bit 8 = 1 stores its level and, in the same `clk` cycle, copies every channel's staged analogue and digital level to the live outputs.
- R5: Addresses 0 to NCH-1 are the analogue attenuation registers of channels 0 to NCH-1. Data bits 6:0 hold the level. Data bit 7 is the channel's zero-cross enable, which drives `ana_zc_o` directly without staging.
- R6: Addresses NCH to 2*NCH-1 are the digital attenuation registers of channels 0 to NCH-1. Data bits 7:0 hold the level.
- R7: Address 2*NCH is the mute register. Data bits NCH-1:0 drive `mute_o` directly, with bit i controlling channel i.
- R8: A write of any data to address 31 (binary 11111) restores every staged and live register to its default.
- R9: A write to any other address leaves every output and every staged value unchanged. This includes writes with data bit 8 set.
- R10: While `rst_n` is low, all registers take their defaults: analogue level 7'h7F, digital level 8'hFF, zero-cross enable 0, and mute all ones (every channel muted).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Latch line; a rising edge accepts the word |
| ana_att_o | output | NCH*7 | Live analogue levels; channel i at bits 7i+6:7i |
| ana_zc_o | output | NCH | Zero-cross enable per channel |
| dig_att_o | output | NCH*8 | Live digital levels; channel i at bits 8i+7:8i |
| mute_o | output | NCH | Mute per channel, 1 = muted |

## Verification
A corrupted staging copy cannot be seen at once. It shows up only at the next commit, when a live level takes a value that was never written to that channel. The bench therefore stages values on several channels and commits them through a write to a different channel. A fault in the word counter or the shift register shows within four clock cycles of a latch edge, either as a dropped write or as a write to the wrong register. Short and long words are used to expose both faults. A default that fails to come back after a software reset is found the next time the restored register is read, including a staged level exposed by a later commit.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 7;
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int ANA_W  = 7;
  localparam int DIG_W  = 8;
  localparam int UPD_BIT = DATA_W - 1;
  localparam int ZC_BIT  = ANA_W;
  localparam logic [ADDR_W-1:0] SRST_ADDR = 7'h1F;
  localparam logic [ANA_W-1:0]  ANA_DEF   = 7'h7F;
  localparam logic [DIG_W-1:0]  DIG_DEF   = 8'hFF;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctl_word_t;
endpackage

// File: rtl/serctl_shift.sv
module serctl_shift
  import serctl_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ser_clk,
  input  logic      ser_dat,
  input  logic      ser_lat,
  output logic      wr_stb,
  output ctl_word_t wr_word
);
  localparam int CW = $clog2(WORD_W + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
  localparam logic [CW-1:0] CNT_OVER = CW'(WORD_W + 1);

  logic [SYNC:0]     sck_q, lat_q;
  logic [SYNC-1:0]   dat_q;
  logic [WORD_W-1:0] shift_q;
  logic [CW-1:0]     cnt_q;
  logic              sck_rise, lat_rise;

  assign sck_rise = sck_q[SYNC-1] & ~sck_q[SYNC];
  assign lat_rise = lat_q[SYNC-1] & ~lat_q[SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      lat_q <= '0;
      dat_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC-1:0], ser_clk};
      lat_q <= {lat_q[SYNC-1:0], ser_lat};
      dat_q <= {dat_q[SYNC-2:0], ser_dat};
    end
  end

  // Word framing: the counter saturates one past a full word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      wr_stb  <= 1'b0;
      wr_word <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (lat_rise) begin
        cnt_q   <= '0;
        wr_stb  <= (cnt_q == CNT_FULL);
        wr_word <= ctl_word_t'(shift_q);
      end else if (sck_rise) begin
        shift_q <= {shift_q[WORD_W-2:0], dat_q[SYNC-1]};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  ctl_word_t            wr_word,
  output logic [NCH*ANA_W-1:0] ana_att_o,
  output logic [NCH-1:0]       ana_zc_o,
  output logic [NCH*DIG_W-1:0] dig_att_o,
  output logic [NCH-1:0]       mute_o
);
  localparam logic [ADDR_W-1:0] DIG_BASE  = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] DIG_END   = ADDR_W'(2 * NCH);
  localparam logic [ADDR_W-1:0] MUTE_ADDR = ADDR_W'(2 * NCH);

  logic is_ana, is_dig, is_mute, is_rst, commit;

  assign is_ana  = wr_word.addr < DIG_BASE;
  assign is_dig  = (wr_word.addr >= DIG_BASE) && (wr_word.addr < DIG_END);
  assign is_mute = wr_word.addr == MUTE_ADDR;
  assign is_rst  = wr_word.addr == SRST_ADDR;
  assign commit  = wr_stb && (is_ana || is_dig) && wr_word.data[UPD_BIT];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [ANA_W-1:0] ana_stg, ana_live;
    logic [DIG_W-1:0] dig_stg, dig_live;
    logic             zc_q;
    logic             hit_ana, hit_dig;
    logic [ANA_W-1:0] ana_next;
    logic [DIG_W-1:0] dig_next;

    assign hit_ana  = wr_stb && (wr_word.addr == ADDR_W'(i));
    assign hit_dig  = wr_stb && (wr_word.addr == ADDR_W'(NCH + i));
    assign ana_next = hit_ana ? wr_word.data[ANA_W-1:0] : ana_stg;
    assign dig_next = hit_dig ? wr_word.data[DIG_W-1:0] : dig_stg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ana_stg  <= ANA_DEF;
        ana_live <= ANA_DEF;
        dig_stg  <= DIG_DEF;
        dig_live <= DIG_DEF;
        zc_q     <= 1'b0;
      end else if (wr_stb && is_rst) begin
        ana_stg  <= ANA_DEF;
        ana_live <= ANA_DEF;
        dig_stg  <= DIG_DEF;
        dig_live <= DIG_DEF;
        zc_q     <= 1'b0;
      end else begin
        ana_stg <= ana_next;
        dig_stg <= dig_next;
        if (hit_ana) zc_q <= wr_word.data[ZC_BIT];
        if (commit) begin
          ana_live <= ana_next;
          dig_live <= dig_next;
        end
      end
    end

    assign ana_att_o[i*ANA_W +: ANA_W] = ana_live;
    assign dig_att_o[i*DIG_W +: DIG_W] = dig_live;
    assign ana_zc_o[i]                 = zc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    mute_o <= '1;
    else if (wr_stb && is_rst)     mute_o <= '1;
    else if (wr_stb && is_mute)    mute_o <= wr_word.data[NCH-1:0];
  end
endmodule

// File: rtl/serctl_bank.sv
module serctl_bank
  import serctl_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 ser_lat,
  output logic [NCH*ANA_W-1:0] ana_att_o,
  output logic [NCH-1:0]       ana_zc_o,
  output logic [NCH*DIG_W-1:0] dig_att_o,
  output logic [NCH-1:0]       mute_o
);
  ctl_word_t         wr_word;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign wr_addr = wr_word.addr;
  assign wr_data = wr_word.data;

  serctl_shift #(.SYNC(SYNC)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .wr_stb(wr_stb), .wr_word(wr_word)
  );

  serctl_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word),
    .ana_att_o(ana_att_o), .ana_zc_o(ana_zc_o),
    .dig_att_o(dig_att_o), .mute_o(mute_o)
  );
endmodule

// File: rtl/serctl_bank_chk.sv
module serctl_bank_chk
  import serctl_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_stb,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic [NCH*ANA_W-1:0] ana_att_o,
  input logic [NCH-1:0]       ana_zc_o,
  input logic [NCH*DIG_W-1:0] dig_att_o,
  input logic [NCH-1:0]       mute_o
);
  logic w_ana, w_dig, w_known;
  logic              q_stb;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data;
  int                q_ch;

  assign w_ana   = wr_addr < ADDR_W'(NCH);
  assign w_dig   = (wr_addr >= ADDR_W'(NCH)) && (wr_addr < ADDR_W'(2 * NCH));
  assign w_known = w_ana || w_dig || wr_addr == ADDR_W'(2 * NCH) || wr_addr == SRST_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_stb  <= 1'b0;
      q_addr <= '0;
      q_data <= '0;
    end else begin
      q_stb  <= wr_stb;
      q_addr <= wr_addr;
      q_data <= wr_data;
    end
  end

  always_comb q_ch = int'(q_addr) % NCH;

  // R3: a staging-only write leaves live levels alone
  p_stage_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (w_ana || w_dig) && !wr_data[UPD_BIT]) |=> ($stable(ana_att_o) && $stable(dig_att_o)));

  // R4: the written level is live right after a commit write
  p_commit_ana_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stb && q_addr < ADDR_W'(NCH) && q_data[UPD_BIT]) |->
      ana_att_o[q_ch*ANA_W +: ANA_W] == q_data[ANA_W-1:0]);

  p_commit_dig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stb && q_addr >= ADDR_W'(NCH) && q_addr < ADDR_W'(2 * NCH) && q_data[UPD_BIT]) |->
      dig_att_o[q_ch*DIG_W +: DIG_W] == q_data[DIG_W-1:0]);

  // R8: software reset brings back mute and zero-cross defaults
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == SRST_ADDR) |=> (mute_o == '1 && ana_zc_o == '0));

  // R9: undefined addresses touch nothing
  p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !w_known) |=> ($stable(ana_att_o) && $stable(dig_att_o) &&
                              $stable(ana_zc_o) && $stable(mute_o)));

  // R1: without an accepted word no output moves
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(ana_att_o) && $stable(dig_att_o) && $stable(ana_zc_o) && $stable(mute_o)));
endmodule

bind serctl_bank serctl_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .ana_att_o(ana_att_o), .ana_zc_o(ana_zc_o), .dig_att_o(dig_att_o), .mute_o(mute_o)
);

// File: tb/sim_serctl_bank.sv
module sim_serctl_bank;
  localparam int NCH = 8;
  localparam int NV  = 11;
  // row: {word[15:0], kind[3:0], chan[3:0], expected[7:0]}
  // kind 0 analogue live, 1 digital live, 2 zero-cross, 3 mute mask
  localparam logic [31:0] VEC [NV] = '{
    {16'h0410, 4'd0, 4'd2, 8'h7F},  // R3 stage ana ch2
    {16'h1A40, 4'd1, 4'd5, 8'hFF},  // R3 R6 stage dig ch5
    {16'h0122, 4'd0, 4'd0, 8'h22},  // R4 R5 commit ana ch0
    {16'h8000, 4'd0, 4'd2, 8'h10},  // R4 R9 ch2 committed; undef addr
    {16'h41FF, 4'd1, 4'd5, 8'h40},  // R4 R9 dig ch5 committed
    {16'h0685, 4'd2, 4'd3, 8'h01},  // R5 zero-cross immediate
    {16'hFD00, 4'd0, 4'd3, 8'h7F},  // R9 undef with update bit
    {16'h20A5, 4'd3, 4'd0, 8'hA5},  // R7 mute mask
    {16'h1380, 4'd1, 4'd1, 8'h80},  // R6 commit dig ch1
    {16'h1380, 4'd0, 4'd3, 8'h05},  // R4 ana ch3 committed
    {16'h23FF, 4'd3, 4'd0, 8'hA5}   // R9 address 2*NCH+1
  };

  logic clk = 1'b0, rst_n = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
  logic [NCH*7-1:0] ana_att_o;
  logic [NCH-1:0]   ana_zc_o;
  logic [NCH*8-1:0] dig_att_o;
  logic [NCH-1:0]   mute_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  serctl_bank #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
    .ana_att_o(ana_att_o), .ana_zc_o(ana_zc_o), .dig_att_o(dig_att_o), .mute_o(mute_o)
  );

  function automatic logic [7:0] obs(input int kind, input int ch);
    case (kind)
      0:       return {1'b0, ana_att_o[ch*7 +: 7]};
      1:       return dig_att_o[ch*8 +: 8];
      2:       return {7'b0, ana_zc_o[ch]};
      default: return mute_o;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [16:0] w, input int nbits);
    for (int b = nbits - 1; b >= 0; b--) begin
      ser_dat = w[b];
      wait_n(3);
      ser_clk = 1'b1;
      wait_n(3);
      ser_clk = 1'b0;
    end
    wait_n(3);
  endtask

  task automatic send_word(input logic [16:0] w, input int nbits);
    shift_bits(w, nbits);
    ser_lat = 1'b1;
    wait_n(3);
    ser_lat = 1'b0;
    wait_n(8);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    // R10: defaults during hardware reset
    check(obs(0, 0), 8'h7F, "R10 ana default");
    check(obs(1, 7), 8'hFF, "R10 dig default");
    check({7'b0, |ana_zc_o}, 8'h00, "R10 zc default");
    check(obs(3, 0), 8'hFF, "R10 mute default");
    rst_n = 1'b1;
    wait_n(4);

    for (int v = 0; v < NV; v++) begin
      send_word({1'b0, VEC[v][31:16]}, 16);
      check(obs(int'(VEC[v][15:12]), int'(VEC[v][11:8])), VEC[v][7:0],
            $sformatf("R1 vector %0d", v));
    end

    // R2: short and long words are ignored
    send_word({1'b0, 16'h017F}, 15);
    check(obs(0, 0), 8'h22, "R2 short word");
    send_word({1'b0, 16'h017F}, 17);
    check(obs(0, 0), 8'h22, "R2 long word");
    send_word({1'b0, 16'h017F}, 16);
    check(obs(0, 0), 8'h7F, "R1 full word");

    // R4: staged ch6/ch7 go live in the same cycle as the ch5 commit, R1 latency
    send_word({1'b0, 16'h0C31}, 16);
    send_word({1'b0, 16'h0E32}, 16);
    shift_bits({1'b0, 16'h0B44}, 16);
    ser_lat = 1'b1;
    begin
      int k = 0;
      while (obs(0, 5) != 8'h44 && k < 10) begin
        check(obs(0, 6), 8'h7F, "R4 ch6 early");
        @(negedge clk);
        k++;
      end
      check((k <= 4) ? 8'h01 : 8'h00, 8'h01, "R1 latency");
      check(obs(0, 6), 8'h31, "R4 ch6 same cycle");
      check(obs(0, 7), 8'h32, "R4 ch7 same cycle");
    end
    wait_n(3);
    ser_lat = 1'b0;
    wait_n(8);

    // R8: software reset
    send_word({1'b0, 16'h1A22}, 16);   // stage dig ch5 = 0x22
    send_word({1'b0, 16'h3E00}, 16);
    check(obs(0, 5), 8'h7F, "R8 ana live");
    check(obs(1, 1), 8'hFF, "R8 dig live");
    check(obs(3, 0), 8'hFF, "R8 mute");
    check(obs(2, 3), 8'h00, "R8 zc");
    send_word({1'b0, 16'h15FF}, 16);
    check(obs(1, 5), 8'hFF, "R8 staged cleared");

    // R10: hardware reset clears staged values too
    send_word({1'b0, 16'h0812}, 16);
    send_word({1'b0, 16'h2000}, 16);
    check(obs(3, 0), 8'h00, "R7 unmute all");
    rst_n = 1'b0;
    wait_n(3);
    check(obs(3, 0), 8'hFF, "R10 mute on reset");
    rst_n = 1'b1;
    wait_n(3);
    send_word({1'b0, 16'h0155}, 16);
    check(obs(0, 0), 8'h55, "R10 commit after reset");
    check(obs(0, 4), 8'h7F, "R10 staged cleared");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule